// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the arithmetic logic unit of a simple load/store processor datapath. It has no clock. Two operands and a 3-bit operation code go in. A result word, a zero flag and a signed-overflow flag come out in the same cycle.

The unit can perform bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Subtraction, less-than and addition all share one adder. For the two subtracting operations, the second operand is inverted and the carry-in is forced to 1. The zero flag lets branch logic test for equality after a subtraction. The overflow flag lets exception logic detect a signed result that is out of range.

Top module: `int_alu`

## Requirements
- R1: Code 3'b000 gives result = opa AND opb, bit by bit.
- R2: Code 3'b001 gives result = opa OR opb, bit by bit.
- R3: Code 3'b010 gives result = (opa + opb) modulo 2^W.
- R4: Code 3'b110 gives result = (opa - opb) modulo 2^W. This is computed as opa plus the inverted opb plus a carry-in of 1.
- R5: Code 3'b111 gives result = 1 when opa < opb as signed two's-complement numbers, and result = 0 otherwise. Bits W-1..1 are always 0. The answer stays correct when the difference overflows.
- R6: zero is 1 exactly when every bit of the result is 0. After code 3'b110 this means opa equals opb.
- R7: Under code 3'b010, ovf is 1 exactly when both operands have the same sign bit and the sign bit of the result differs from it.
- R8: Under code 3'b110, ovf is 1 exactly when the operands have different sign bits and the sign bit of the result differs from the sign bit of opa.
- R9: Under codes 3'b000, 3'b001 and 3'b111, ovf is 0.
- R10: Codes 3'b011, 3'b100 and 3'b101 give a result of 0 and ovf = 0. zero therefore reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W (32) | First operand |
| opb | input | W (32) | Second operand |
| op | input | 3 | Operation code |
| res | output | W (32) | Result word |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so any wrong internal value shows up at once on res, zero or ovf for the same input pattern. The faults most likely to hide are in the sign bit and the carry-in: a missing carry-in, a wrong inversion, or a less-than decision that ignores overflow. Each of these appears only for particular operands. The sweep therefore crosses every operation code with operands at the signed extremes, at ±1 and at zero, so that each such fault is seen for the first input that exercises it.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         ovf
);
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  logic         negate;
  logic [W-1:0] opb_eff;
  logic [W-1:0] sum;
  logic         sum_ovf;
  logic         less;

  assign negate  = op[2];
  assign opb_eff = opb ^ {W{negate}};
  assign sum     = opa + opb_eff + {{(W-1){1'b0}}, negate};
  assign sum_ovf = (opa[W-1] == opb_eff[W-1]) && (sum[W-1] != opa[W-1]);
  assign less    = sum[W-1] ^ sum_ovf;

  always_comb begin
    res = '0;
    ovf = 1'b0;
    unique case (op)
      OP_AND: res = opa & opb;
      OP_OR:  res = opa | opb;
      OP_ADD: begin res = sum; ovf = sum_ovf; end
      OP_SUB: begin res = sum; ovf = sum_ovf; end
      OP_SLT: res = {{(W-1){1'b0}}, less};
      default: ;
    endcase
  end

  assign zero = ~|res;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   op,
  input logic [W-1:0] res,
  input logic         zero,
  input logic         ovf
);
  always_comb begin
    if (op == 3'b010)
      a_r3_add_wraps: assert (res == opa + opb);
    if (op == 3'b110)
      a_r4_sub_inverts: assert (res + opb == opa);
    if (op == 3'b111)
      a_r5_less_signed: assert (res == {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))});
    if (op == 3'b110 && zero)
      a_r6_equal_on_zero: assert (opa == opb);
    if (op == 3'b010)
      a_r7_add_overflow: assert (ovf == ((opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1])));
    if (op == 3'b110)
      a_r8_sub_overflow: assert (ovf == ((opa[W-1] != opb[W-1]) && (res[W-1] != opa[W-1])));
    if (op == 3'b000 || op == 3'b001 || op == 3'b111)
      a_r9_no_overflow: assert (!ovf);
    if (op == 3'b011 || op == 3'b100 || op == 3'b101)
      a_r10_unused_quiet: assert (res == '0 && !ovf && zero);
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [2:0] op = 3'b011;
  logic [W-1:0] res;
  logic zero, ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  int_alu #(.W(W)) u_int_alu (
    .opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf)
  );

  function automatic logic [W-1:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'h0000_0002;   3: return 32'hFFFF_FFFF;
      4: return 32'hFFFF_FFFE;   5: return 32'h7FFF_FFFF;
      6: return 32'h8000_0000;   7: return 32'h8000_0001;
      8: return 32'h7FFF_FFFE;   9: return 32'h5555_5555;
      10: return 32'hAAAA_AAAA;  11: return 32'h1234_5678;
      12: return 32'hFEDC_BA98;  13: return 32'h4000_0000;
      14: return 32'hC000_0000;  default: return 32'h0000_FFFF;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, wide;
    logic [W-1:0] er;
    logic eo;
    string rtag, otag;
    @(posedge clk);
    op = o; opa = a; opb = b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    er = '0; eo = 1'b0; rtag = "R10"; otag = "R10";
    case (o)
      3'b000: begin er = a & b; rtag = "R1"; otag = "R9"; end
      3'b001: begin er = a | b; rtag = "R2"; otag = "R9"; end
      3'b010: begin wide = sa + sb; er = W'(wide); rtag = "R3"; otag = "R7";
                eo = (wide > 64'sh7FFF_FFFF) || (wide < -64'sh8000_0000); end
      3'b110: begin wide = sa - sb; er = W'(wide); rtag = "R4"; otag = "R8";
                eo = (wide > 64'sh7FFF_FFFF) || (wide < -64'sh8000_0000); end
      3'b111: begin er = (sa < sb) ? 1 : 0; rtag = "R5"; otag = "R9"; end
      default: ;
    endcase
    @(negedge clk);
    check(rtag, res, er);
    check("R6", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
    check(otag, {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, eo});
  endtask

  initial begin
    logic [W-1:0] lfsr_a, lfsr_b;
    @(negedge clk);
    check("R10", res, '0);
    check("R6", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(3'(o), corner(i), corner(j));
    lfsr_a = 32'hACE1_2468; lfsr_b = 32'h1357_9BDF;
    for (int k = 0; k < 400; k++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      for (int o = 0; o < 8; o++) begin
        apply(3'(o), lfsr_a, lfsr_b);
        apply(3'(o), lfsr_a, lfsr_a);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule